// File: doc/BRIEF.md
# DRAM Controller Performance Counter Unit

This unit sits beside a DRAM controller and counts what the controller does. Every clock cycle the controller presents a vector of event strobes, one line per event source: host reads and writes, activates, precharges, refreshes, hazards, and power-state entries. It also presents two dedicated strobes, one for each DRAM read beat and one for each write beat. Eight programmable counters each pick any subset of the event lines through a bitmap. Two fixed counters count only the read and write beats.

Software reaches the unit through a 64-bit register port with a single address bus, a write strobe and a combinational read-data output. A small control state machine governs the programmable set. It has three states. `ST_IDLE` is the state after reset. `ST_RUN` is the counting state. `ST_DONE` means counting has ended.

The machine has three transitions. The launch transition takes `ST_IDLE` to `ST_RUN` when a start command is written in manual mode. The halt transition takes `ST_RUN` to `ST_DONE` when a stop command is written. The relaunch transition takes `ST_DONE` back to `ST_RUN` on a start command in manual mode. Both launch and relaunch zero every programmable counter. The fixed counters have their own enable and clear registers and do not depend on this machine.

Top module: `dram_perf_monitor`

Register map, byte addresses:

| Address | Access | Contents |
|---|---|---|
| 0x000 | read/write | Mode. Bit 0 = 1 selects manual mode. |
| 0x008 | write / read | Start. Writing bit 0 = 1 issues a start command. Reading returns bit 1 = active. |
| 0x010 | write only | Stop. Writing bit 0 = 1 issues a stop command. Reads return 0. |
| 0x018 | read only | Status. Bit 0 = counting has ended. |
| 0x020 | read/write | Fixed-counter enable. Bit 0 = write counter, bit 1 = read counter. |
| 0x028 | write only | Fixed-counter clear. Bit 0 = write counter, bit 1 = read counter. Reads return 0. |
| 0x030 | read only | Fixed write-counter value. |
| 0x038 | read only | Fixed read-counter value. |
| 0x100 + 8·n | read/write | Configuration of programmable counter n. |
| 0x180 + 8·n | read only | Value of programmable counter n. |

## Requirements
- R1: After reset every register reads zero and the control machine is in `ST_IDLE`.
- R2: In a configuration register, bit 63 is the counter enable and bits EVT_W-1:0 are the event bitmap. All other bits are discarded on write and read back as zero.
- R3: The event with ID k is selected by bitmap bit k-1. The power-state events with IDs 27, 31 and 35 each span four adjacent bits starting at bit k-1. A counter adds exactly one in each cycle in which any of its selected event lines is high, however many of them are high.
- R4: A programmable counter does not change while its enable bit is clear, nor while the machine is not in `ST_RUN`.
- R5: Writing 1 to bit 0 of the start register moves the machine from `ST_IDLE` or `ST_DONE` to `ST_RUN`, but only when mode bit 0 is 1. A start command is ignored while the machine is in `ST_RUN`. Reading the start register returns 2 (bit 1 set) exactly while the machine is in `ST_RUN`, and 0 otherwise.
- R6: Writing 1 to bit 0 of the stop register in `ST_RUN` moves the machine to `ST_DONE`. Status bit 0 reads 1 in `ST_DONE`, and the programmable counters then hold their values.
- R7: Every transition into `ST_RUN` resets every programmable counter to zero.
- R8: A programmable counter is CNT_W+1 bits wide. Bit CNT_W becomes set when the count passes 2^CNT_W-1. Once all CNT_W+1 bits are ones, the counter holds that value.
- R9: In the fixed-counter enable register, bit 0 enables the write-beat counter and bit 1 enables the read-beat counter. Each enabled counter adds one per cycle its beat strobe is high, in any machine state.
- R10: Writing the fixed-counter clear register zeroes the write counter when bit 0 is 1 and the read counter when bit 1 is 1. A clear takes priority over a beat in the same cycle.
- R11: The fixed counters are CNT_W bits wide and wrap to zero after 2^CNT_W-1.
- R12: The value registers are read-only: a write to a value address leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address for both reads and writes |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr, combinational |
| event_strobe | input | EVT_W | Per-cycle event lines from the controller |
| rd_beat | input | 1 | DRAM read beat strobe |
| wr_beat | input | 1 | DRAM write beat strobe |

## Verification
The programmable counters are driven in several ways, each of which separates one cause from another:
- A single selected line counts while the machine is stopped, and again while it is running. This separates state gating from event selection.
- A bitmap identical to a working one but with the enable bit clear shows that the enable is honoured.
- Different lines within a four-bit group, and several selected lines together, show that the selection is an OR that counts once per cycle, not a sum.
- Long bursts on a narrow build (CNT_W=6) step through overflow into saturation, and drive the fixed write counter through a wrap.

Beats are applied with only one fixed counter enabled, and a beat coincides with a clear. These cases show the two fixed counters are independent and that the clear takes priority.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } run_state_e;

    localparam int unsigned A_MODE     = 'h000;
    localparam int unsigned A_START    = 'h008;
    localparam int unsigned A_STOP     = 'h010;
    localparam int unsigned A_STATUS   = 'h018;
    localparam int unsigned A_FR_EN    = 'h020;
    localparam int unsigned A_FR_CLR   = 'h028;
    localparam int unsigned A_FR_WRVAL = 'h030;
    localparam int unsigned A_FR_RDVAL = 'h038;
    localparam int unsigned A_CFG_BASE = 'h100;
    localparam int unsigned A_VAL_BASE = 'h180;
    localparam int unsigned CFG_EN_BIT = 63;

endpackage

// File: rtl/dpm_ctrl_fsm.sv
module dpm_ctrl_fsm
    import dpm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic stop_req,
    input  logic manual,
    output logic run,
    output logic done,
    output logic clear_cnt
);
    run_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and outputs: launch, halt, relaunch.
    always_comb begin
        state_d   = state_q;
        run       = 1'b0;
        done      = 1'b0;
        clear_cnt = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req && manual) begin
                    state_d   = ST_RUN;
                    clear_cnt = 1'b1;
                end
            end
            ST_RUN: begin
                run = 1'b1;
                if (stop_req) state_d = ST_DONE;
            end
            ST_DONE: begin
                done = 1'b1;
                if (start_req && manual) begin
                    state_d   = ST_RUN;
                    clear_cnt = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/dpm_event_counter.sv
module dpm_event_counter #(
    parameter int EVT_W = 56,
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             enable,
    input  logic [EVT_W-1:0] sel_map,
    input  logic [EVT_W-1:0] events,
    output logic [CNT_W:0]   value
);
    localparam int VW = CNT_W + 1;
    localparam logic [VW-1:0] SAT = '1;

    logic hit, step;
    assign hit  = |(sel_map & events);
    assign step = run && enable && hit;

    always_ff @(posedge clk) begin
        if (!rst_n)                      value <= '0;
        else if (clear)                  value <= '0;
        else if (step && value != SAT)   value <= value + 1'b1;
    end
endmodule

// File: rtl/dpm_free_counter.sv
module dpm_free_counter #(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             enable,
    input  logic             beat,
    output logic [CNT_W-1:0] value
);
    always_ff @(posedge clk) begin
        if (!rst_n)               value <= '0;
        else if (clear)           value <= '0;
        else if (enable && beat)  value <= value + 1'b1;
    end
endmodule

// File: rtl/dram_perf_monitor.sv
module dram_perf_monitor
    import dpm_pkg::*;
#(
    parameter int N_PROG = 8,
    parameter int EVT_W  = 56,
    parameter int CNT_W  = 48,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    input  logic [EVT_W-1:0]  event_strobe,
    input  logic              rd_beat,
    input  logic              wr_beat
);
    logic                           mode_manual;
    logic [1:0]                     fr_en;
    logic [N_PROG-1:0]              cfg_en;
    logic [N_PROG-1:0][EVT_W-1:0]   cfg_map;
    logic [N_PROG-1:0][CNT_W:0]     prog_val;
    logic [CNT_W-1:0]               fr_wr_val, fr_rd_val;
    logic                           run_st, done_st, clear_prog;
    logic                           wr_mode, wr_start, wr_stop, wr_fren, wr_frclr;
    logic                           clr_wr, clr_rd;
    logic                           unused_wdata;

    assign wr_mode  = reg_wr && (reg_addr == ADDR_W'(A_MODE));
    assign wr_start = reg_wr && (reg_addr == ADDR_W'(A_START))  && reg_wdata[0];
    assign wr_stop  = reg_wr && (reg_addr == ADDR_W'(A_STOP))   && reg_wdata[0];
    assign wr_fren  = reg_wr && (reg_addr == ADDR_W'(A_FR_EN));
    assign wr_frclr = reg_wr && (reg_addr == ADDR_W'(A_FR_CLR));
    assign clr_wr   = wr_frclr && reg_wdata[0];
    assign clr_rd   = wr_frclr && reg_wdata[1];
    assign unused_wdata = ^reg_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_manual <= 1'b0;
            fr_en       <= '0;
        end else begin
            if (wr_mode) mode_manual <= reg_wdata[0];
            if (wr_fren) fr_en       <= reg_wdata[1:0];
        end
    end

    dpm_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (wr_start),
        .stop_req  (wr_stop),
        .manual    (mode_manual),
        .run       (run_st),
        .done      (done_st),
        .clear_cnt (clear_prog)
    );

    for (genvar i = 0; i < N_PROG; i++) begin : g_prog
        logic wr_cfg;
        assign wr_cfg = reg_wr && (reg_addr == ADDR_W'(A_CFG_BASE + 8 * i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_en[i]  <= 1'b0;
                cfg_map[i] <= '0;
            end else if (wr_cfg) begin
                cfg_en[i]  <= reg_wdata[CFG_EN_BIT];
                cfg_map[i] <= reg_wdata[EVT_W-1:0];
            end
        end

        dpm_event_counter #(.EVT_W(EVT_W), .CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (clear_prog),
            .run     (run_st),
            .enable  (cfg_en[i]),
            .sel_map (cfg_map[i]),
            .events  (event_strobe),
            .value   (prog_val[i])
        );
    end

    dpm_free_counter #(.CNT_W(CNT_W)) u_fr_wr (
        .clk (clk), .rst_n (rst_n), .clear (clr_wr),
        .enable (fr_en[0]), .beat (wr_beat), .value (fr_wr_val)
    );

    dpm_free_counter #(.CNT_W(CNT_W)) u_fr_rd (
        .clk (clk), .rst_n (rst_n), .clear (clr_rd),
        .enable (fr_en[1]), .beat (rd_beat), .value (fr_rd_val)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(A_MODE))     reg_rdata[0]   = mode_manual;
        if (reg_addr == ADDR_W'(A_START))    reg_rdata[1]   = run_st;
        if (reg_addr == ADDR_W'(A_STATUS))   reg_rdata[0]   = done_st;
        if (reg_addr == ADDR_W'(A_FR_EN))    reg_rdata[1:0] = fr_en;
        if (reg_addr == ADDR_W'(A_FR_WRVAL)) reg_rdata[CNT_W-1:0] = fr_wr_val;
        if (reg_addr == ADDR_W'(A_FR_RDVAL)) reg_rdata[CNT_W-1:0] = fr_rd_val;
        for (int i = 0; i < N_PROG; i++) begin
            if (reg_addr == ADDR_W'(A_CFG_BASE + 8 * i)) begin
                reg_rdata[CFG_EN_BIT]  = cfg_en[i];
                reg_rdata[EVT_W-1:0]   = cfg_map[i];
            end
            if (reg_addr == ADDR_W'(A_VAL_BASE + 8 * i))
                reg_rdata[CNT_W:0] = prog_val[i];
        end
    end
endmodule

// File: rtl/dpm_checker.sv
module dpm_checker #(
    parameter int CNT_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             done,
    input logic             launch,
    input logic [CNT_W:0]   val0,
    input logic [CNT_W-1:0] fr_w,
    input logic             fr_w_clr,
    input logic             fr_w_en,
    input logic             wr_beat
);
    p_launch_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (val0 == '0));

    p_hold_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !launch) |=> $stable(val0));

    p_halt_from_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(run));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !launch |=> (val0 == $past(val0)) || (val0 == (CNT_W+1)'($past(val0) + 1'b1)));

    p_saturate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((&val0) && !launch) |=> (&val0));

    p_free_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_w_en && wr_beat && !fr_w_clr) |=> (fr_w == CNT_W'($past(fr_w) + 1'b1)));

    p_free_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fr_w_clr |=> (fr_w == '0));
endmodule

bind dram_perf_monitor dpm_checker #(.CNT_W(CNT_W)) u_dpm_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_st),
    .done     (done_st),
    .launch   (clear_prog),
    .val0     (prog_val[0]),
    .fr_w     (fr_wr_val),
    .fr_w_clr (clr_wr),
    .fr_w_en  (fr_en[0]),
    .wr_beat  (wr_beat)
);

// File: tb/tb_dram_perf_monitor.sv
module tb_dram_perf_monitor;
    import dpm_pkg::*;

    localparam int EVT_W  = 56;
    localparam int CNT_W  = 6;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [63:0]       reg_wdata = '0;
    logic [63:0]       reg_rdata;
    logic [EVT_W-1:0]  event_strobe = '0;
    logic              rd_beat = 1'b0;
    logic              wr_beat = 1'b0;

    int checks = 0;
    int fails  = 0;
    logic probe = 1'b0;
    logic finished = 1'b0;

    typedef struct {
        logic [63:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    dram_perf_monitor #(.N_PROG(8), .EVT_W(EVT_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) dut (
        .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .event_strobe (event_strobe),
        .rd_beat (rd_beat), .wr_beat (wr_beat)
    );

    // Monitor: compare read data against the scoreboard head.
    always @(negedge clk) begin
        if (probe) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (reg_rdata !== it.exp) begin
                fails++;
                $display("FAIL %s actual=%h expected=%h", it.tag, reg_rdata, it.exp);
            end
        end
    end

    task automatic wr(input int unsigned a, input logic [63:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic expect_rd(input int unsigned a, input logic [63:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        reg_addr = ADDR_W'(a);
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        probe = 1'b1;
        @(negedge clk); #1;
        probe = 1'b0;
    endtask

    task automatic pulse(input logic [EVT_W-1:0] ev, input int n);
        @(posedge clk); #1;
        event_strobe = ev;
        repeat (n) @(posedge clk);
        #1 event_strobe = '0;
    endtask

    task automatic beats(input logic r, input logic w, input int n);
        @(posedge clk); #1;
        rd_beat = r; wr_beat = w;
        repeat (n) @(posedge clk);
        #1 rd_beat = 1'b0; wr_beat = 1'b0;
    endtask

    function automatic int unsigned cfg_a(input int n); return A_CFG_BASE + 8 * n; endfunction
    function automatic int unsigned val_a(input int n); return A_VAL_BASE + 8 * n; endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        expect_rd(A_MODE,     64'd0, "R1 mode");
        expect_rd(cfg_a(0),   64'd0, "R1 cfg0");
        expect_rd(val_a(0),   64'd0, "R1 val0");
        expect_rd(A_START,    64'd0, "R1 active");
        expect_rd(A_STATUS,   64'd0, "R1 status");
        expect_rd(A_FR_WRVAL, 64'd0, "R1 fr_wr");
        expect_rd(A_FR_RDVAL, 64'd0, "R1 fr_rd");

        wr(A_MODE, 64'd1);
        expect_rd(A_MODE, 64'd1, "R5 mode manual");

        // R2 config fields
        wr(cfg_a(0), (64'd1 << 63) | (64'd1 << 60) | 64'd4);
        expect_rd(cfg_a(0), (64'd1 << 63) | 64'd4, "R2 cfg0 readback");
        wr(cfg_a(1), (64'd1 << 63) | (64'hF << 26));
        wr(cfg_a(2), 64'd4);

        // R4 not started
        pulse(56'd1 << 2, 5);
        expect_rd(val_a(0), 64'd0, "R4 idle no count");

        wr(A_START, 64'd1);
        expect_rd(A_START, 64'd2, "R5 active after start");

        // R3 single line
        pulse(56'd1 << 2, 7);
        expect_rd(val_a(0), 64'd7, "R3 val0 event 3");
        expect_rd(val_a(2), 64'd0, "R4 disabled counter");
        // R3 group lines
        pulse(56'd1 << 28, 3);
        expect_rd(val_a(1), 64'd3, "R3 group member");
        pulse((56'd1 << 26) | (56'd1 << 29) | (56'd1 << 2), 2);
        expect_rd(val_a(1), 64'd5, "R3 OR counts once");
        expect_rd(val_a(0), 64'd9, "R3 val0 after OR");

        // R6 stop
        wr(A_STOP, 64'd1);
        expect_rd(A_STATUS, 64'd1, "R6 status ended");
        expect_rd(A_START,  64'd0, "R6 inactive");
        pulse(56'd1 << 2, 4);
        expect_rd(val_a(0), 64'd9, "R6 hold after stop");

        // R7 restart clears
        wr(A_START, 64'd1);
        expect_rd(val_a(0), 64'd0, "R7 val0 cleared");
        expect_rd(val_a(1), 64'd0, "R7 val1 cleared");
        expect_rd(A_STATUS, 64'd0, "R7 status cleared");

        // R8 overflow and saturation
        pulse(56'd1 << 2, 70);
        expect_rd(val_a(0), 64'd70, "R8 overflow flag");
        pulse(56'd1 << 2, 60);
        expect_rd(val_a(0), 64'd127, "R8 saturate");

        // R5 start ignored while running
        wr(A_START, 64'd1);
        expect_rd(val_a(0), 64'd127, "R5 start in run ignored");

        // R12 value read-only
        wr(val_a(0), 64'd0);
        expect_rd(val_a(0), 64'd127, "R12 value write ignored");

        // R5 start needs manual mode
        wr(A_MODE, 64'd0);
        wr(A_STOP, 64'd1);
        wr(A_START, 64'd1);
        expect_rd(A_START,  64'd0, "R5 start ignored not manual");
        expect_rd(A_STATUS, 64'd1, "R5 still ended");
        wr(A_MODE, 64'd1);

        // R9 fixed counters
        wr(A_FR_EN, 64'd1);
        beats(1'b1, 1'b1, 5);
        expect_rd(A_FR_WRVAL, 64'd5, "R9 write counter");
        expect_rd(A_FR_RDVAL, 64'd0, "R9 read disabled");
        wr(A_FR_EN, 64'd3);
        beats(1'b1, 1'b0, 3);
        expect_rd(A_FR_RDVAL, 64'd3, "R9 read counter");
        expect_rd(A_FR_WRVAL, 64'd5, "R9 write unchanged");

        // R10 clears
        wr(A_FR_CLR, 64'd2);
        expect_rd(A_FR_RDVAL, 64'd0, "R10 read cleared");
        expect_rd(A_FR_WRVAL, 64'd5, "R10 write kept");
        @(posedge clk); #1;
        wr_beat = 1'b1; reg_wr = 1'b1; reg_addr = ADDR_W'(A_FR_CLR); reg_wdata = 64'd1;
        @(posedge clk); #1;
        wr_beat = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        expect_rd(A_FR_WRVAL, 64'd0, "R10 clear beats beat");

        // R11 wrap
        beats(1'b0, 1'b1, 65);
        expect_rd(A_FR_WRVAL, 64'd1, "R11 wrap");

        repeat (2) @(posedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule